// File: doc/BRIEF.md
# Smart card character receiver

This block receives characters on a half-duplex asynchronous smart card line that uses a character protocol with error signalling. It watches the I/O line, which is idle high, through a synchronizer. On a falling edge it times each bit against a fixed number of receiver clock cycles and samples the line at the middle of every bit. It assembles a ten-bit character: a start bit, eight data bits sent least significant bit first, and an even parity bit.

When the parity is correct, the byte goes into the receive data register and the receive-full flag is raised. When the parity is wrong, the byte is discarded, the parity-error flag is raised, and the block pulls the open-drain line low for one bit period in the guard time. That low level asks the sender to send the character again. The line pad is modelled as a plain input plus a pull-low enable. A read strobe from the host, or from a transfer agent triggered by the receive interrupt, clears the full flag. A separate clear strobe clears the parity-error flag.

Top module: `sc_char_rx`

## Requirements
- R1: After reset, `rx_full`, `par_err`, `rx_irq`, `err_irq` and `io_pull_low` are 0, and `rx_data` is 0.
- R2: One bit lasts `ETU_CYCLES` clock cycles (default 372), and each bit is sampled in the middle of its period. A character is a low start bit, then 8 data bits least significant bit first, then a parity bit.
- R3: A character whose parity bit makes the number of ones across data and parity even loads its byte into `rx_data` and sets `rx_full`.
- R4: `rx_irq` is high exactly when `rx_full` and `rx_ie` are both 1. `err_irq` is high exactly when `par_err` and `rx_ie` are both 1.
- R5: A character with odd total parity sets `par_err`. It leaves `rx_full` unchanged, and `rx_data` keeps the last good byte.
- R6: After a parity error, `io_pull_low` goes to 1 about 10.5 bit periods after the start edge, stays at 1 for exactly `ETU_CYCLES` cycles, and then returns to 0. It is 1 at the 11-bit-period point.
- R7: After a character with correct parity, `io_pull_low` stays 0 for the whole guard time.
- R8: A one-cycle pulse on `rd_strobe` clears `rx_full` and leaves `rx_data` unchanged. Without a read, `rx_full` stays set.
- R9: Once set, `par_err` stays set until `per_clr` is pulsed. A second parity error that arrives while the flag is still set leaves it set.
- R10: A low pulse on the line that is high again at the start bit's mid-point is treated as a false start. Nothing is received, and the next real character is received correctly.
- R11: `rx_data` changes only on a cycle in which a good character is accepted, which is a cycle that also leaves `rx_full` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_in | input | 1 | Level read back from the open-drain I/O line |
| io_pull_low | output | 1 | 1 drives the I/O line low (error signal) |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_strobe | input | 1 | Read of the receive data register; clears `rx_full` |
| per_clr | input | 1 | Clears the parity-error flag |
| rx_data | output | 8 | Last correctly received byte |
| rx_full | output | 1 | A new byte is waiting in `rx_data` |
| par_err | output | 1 | Sticky parity-error flag |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Some properties are checked by the bound checker on every cycle:
- `rx_full` and `par_err` stay set until their clear strobes arrive.
- `rx_data` moves only together with an accepted character.
- Neither interrupt fires while `rx_ie` is 0.
- Every error pulse lasts exactly one bit period.
- The line is never pulled low at the moment a good character sets `rx_full`.

Other behaviour is shown only by the bench's scenarios:
- Correct bit order and parity decoding for specific bytes.
- The position of the error pulse relative to the start edge.
- Rejection of a glitch as a false start.
- Keeping the last good byte across rejected characters.

// File: rtl/sc_rx_pkg.sv
package sc_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RECV   = 2'd1,
    ST_ERRSIG = 2'd2
  } rx_state_e;

  // Extra bit slots after the parity bit: one to start the error signal, one to end it
  localparam int unsigned GUARD_SLOTS = 2;

endpackage

// File: rtl/sc_rx_sync.sv
module sc_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic line_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = pin_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/sc_rx_etu_timer.sv
module sc_rx_etu_timer #(
  parameter int unsigned ETU_CYCLES = 372,
  parameter int unsigned SLOTS      = 12,
  localparam int unsigned CW        = (ETU_CYCLES > 1) ? $clog2(ETU_CYCLES) : 1,
  localparam int unsigned IW        = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  output logic          mid_o,
  output logic [IW-1:0] bidx_o
);

  localparam logic [CW-1:0] LAST = CW'(ETU_CYCLES - 1);
  localparam logic [CW-1:0] HALF = CW'(ETU_CYCLES / 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          cnt_en;

  assign cnt_en = start_i | run_i;

  always_comb begin
    cnt_d = cnt_q;
    idx_d = idx_q;
    if (start_i) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (run_i) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        idx_d = idx_q + 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign mid_o  = run_i & ~start_i & (cnt_q == HALF);
  assign bidx_o = idx_q;

endmodule

// File: rtl/sc_rx_shift.sv
module sc_rx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              parity_ok_o
);

  logic [DATA_W-1:0] sh_q, sh_d;

  // The least significant bit arrives first, so bits shift in at the top and move down
  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {bit_i, sh_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= sh_d;
  end

  assign data_o = sh_q;
  // Even parity: data bits plus the parity bit now on the line hold an even count of ones
  assign parity_ok_o = ~(^sh_q ^ bit_i);

endmodule

// File: rtl/sc_rx_flags.sv
module sc_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              reject_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              rd_strobe,
  input  logic              per_clr,
  input  logic              rx_ie,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              rx_irq,
  output logic              err_irq
);

  logic [DATA_W-1:0] data_q;
  logic              full_q, full_d;
  logic              per_q, per_d;

  // A new event wins over a clear strobe in the same cycle
  always_comb begin
    full_d = full_q;
    if (rd_strobe) full_d = 1'b0;
    if (accept_i)  full_d = 1'b1;
    per_d = per_q;
    if (per_clr)   per_d = 1'b0;
    if (reject_i)  per_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      per_q  <= 1'b0;
    end else begin
      if (accept_i) data_q <= byte_i;
      full_q <= full_d;
      per_q  <= per_d;
    end
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign par_err = per_q;
  assign rx_irq  = full_q & rx_ie;
  assign err_irq = per_q & rx_ie;

endmodule

// File: rtl/sc_char_rx.sv
module sc_char_rx
  import sc_rx_pkg::*;
#(
  parameter int unsigned ETU_CYCLES  = 372,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_in,
  output logic              io_pull_low,
  input  logic              rx_ie,
  input  logic              rd_strobe,
  input  logic              per_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              par_err,
  output logic              rx_irq,
  output logic              err_irq
);

  localparam int unsigned PAR_SLOT = DATA_W + 1;
  localparam int unsigned SLOTS    = PAR_SLOT + 1 + GUARD_SLOTS;
  localparam int unsigned IW       = $clog2(SLOTS + 1);
  localparam logic [IW-1:0] IDX_START = '0;
  localparam logic [IW-1:0] IDX_PAR   = IW'(PAR_SLOT);
  localparam logic [IW-1:0] IDX_ERR_ON  = IW'(PAR_SLOT + 1);
  localparam logic [IW-1:0] IDX_ERR_OFF = IW'(PAR_SLOT + 2);

  rx_state_e   state_q, state_d;
  logic        pull_q, pull_d;
  logic        line, fall;
  logic        start, run, mid;
  logic [IW-1:0] bidx;
  logic        shift_en, par_ok, accept, reject;
  logic [DATA_W-1:0] sh_byte;

  sc_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (io_in),
    .line_o(line),
    .fall_o(fall)
  );

  sc_rx_etu_timer #(.ETU_CYCLES(ETU_CYCLES), .SLOTS(SLOTS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start),
    .run_i  (run),
    .mid_o  (mid),
    .bidx_o (bidx)
  );

  sc_rx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .bit_i      (line),
    .data_o     (sh_byte),
    .parity_ok_o(par_ok)
  );

  sc_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .reject_i (reject),
    .byte_i   (sh_byte),
    .rd_strobe(rd_strobe),
    .per_clr  (per_clr),
    .rx_ie    (rx_ie),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .par_err  (par_err),
    .rx_irq   (rx_irq),
    .err_irq  (err_irq)
  );

  assign run = (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    pull_d   = pull_q;
    start    = 1'b0;
    shift_en = 1'b0;
    accept   = 1'b0;
    reject   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fall) begin
          start   = 1'b1;
          state_d = ST_RECV;
        end
      end
      ST_RECV: begin
        if (mid) begin
          if (bidx == IDX_START) begin
            if (line) state_d = ST_IDLE;   // glitch: start bit did not hold
          end else if (bidx == IDX_PAR) begin
            if (par_ok) begin
              accept  = 1'b1;
              state_d = ST_IDLE;
            end else begin
              reject  = 1'b1;
              state_d = ST_ERRSIG;
            end
          end else begin
            shift_en = 1'b1;
          end
        end
      end
      ST_ERRSIG: begin
        if (mid && bidx == IDX_ERR_ON) pull_d = 1'b1;
        if (mid && bidx == IDX_ERR_OFF) begin
          pull_d  = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
        pull_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pull_q  <= pull_d;
    end
  end

  assign io_pull_low = pull_q;

endmodule

// File: rtl/sc_char_rx_chk.sv
module sc_char_rx_chk #(
  parameter int unsigned ETU_CYCLES = 372,
  parameter int unsigned DATA_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_pull_low,
  input logic              rx_ie,
  input logic              rd_strobe,
  input logic              per_clr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_full,
  input logic              par_err,
  input logic              rx_irq,
  input logic              err_irq
);

  int unsigned pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pw_q <= 0;
    else if (io_pull_low) pw_q <= pw_q + 1;
    else                  pw_q <= 0;
  end

  p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_strobe) |=> rx_full);

  p_per_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !per_clr) |=> par_err);

  p_data_on_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data) |-> rx_full);

  p_pull_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_pull_low) |-> (pw_q == ETU_CYCLES));

  p_pull_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    io_pull_low |-> (pw_q < ETU_CYCLES));

  p_no_pull_on_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !io_pull_low);

  p_irq_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq || err_irq) |-> rx_ie);

endmodule

bind sc_char_rx sc_char_rx_chk #(.ETU_CYCLES(ETU_CYCLES), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_pull_low(io_pull_low),
  .rx_ie      (rx_ie),
  .rd_strobe  (rd_strobe),
  .per_clr    (per_clr),
  .rx_data    (rx_data),
  .rx_full    (rx_full),
  .par_err    (par_err),
  .rx_irq     (rx_irq),
  .err_irq    (err_irq)
);

// File: tb/sim_sc_char_rx.sv
module sim_sc_char_rx;

  localparam int CLK_PERIOD = 10;
  localparam int ETU        = 372;
  localparam int NVEC       = 6;
  // each entry: {rx_ie, corrupt parity, data byte}
  localparam logic [9:0] VEC [NVEC] = '{10'h2A5, 10'h03C, 10'h3FF, 10'h100, 10'h280, 10'h201};

  logic       clk, rst_n;
  logic       line_tx, io_in, io_pull_low;
  logic       rx_ie, rd_strobe, per_clr;
  logic [7:0] rx_data;
  logic       rx_full, par_err, rx_irq, err_irq;

  int checks, errors;
  int pull_cnt;
  logic pull_mid;
  logic [7:0] exp_data;
  bit done;

  assign io_in = line_tx & ~io_pull_low;

  sc_char_rx #(.ETU_CYCLES(ETU)) u0 (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .io_pull_low(io_pull_low),
    .rx_ie(rx_ie), .rd_strobe(rd_strobe), .per_clr(per_clr),
    .rx_data(rx_data), .rx_full(rx_full), .par_err(par_err),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends one character; it then watches the guard time for 3 bit periods
  task automatic send_frame(input logic [7:0] d, input bit bad);
    logic [9:0] bits;
    bits = {(^d) ^ bad, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      line_tx = bits[b];
      repeat (ETU) @(negedge clk);
    end
    line_tx  = 1'b1;
    pull_cnt = 0;
    pull_mid = 1'b0;
    for (int c = 0; c < 3*ETU; c++) begin
      if (io_pull_low) pull_cnt++;
      if (c == ETU) pull_mid = io_pull_low;
      @(negedge clk);
    end
  endtask

  task automatic clear_flags();
    rd_strobe = 1'b1;
    per_clr   = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    per_clr   = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 0;
    line_tx = 1'b1; rx_ie = 1'b0; rd_strobe = 1'b0; per_clr = 1'b0;
    rst_n = 1'b0;
    exp_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk(rx_full == 0 && par_err == 0, "R1 flags", {rx_full, par_err}, 0);
    chk(rx_irq == 0 && err_irq == 0 && io_pull_low == 0, "R1 irq/pull", {rx_irq, err_irq, io_pull_low}, 0);
    chk(rx_data == 8'h00, "R1 data", rx_data, 0);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] d;
      bit bad, ie;
      d = VEC[i][7:0]; bad = VEC[i][8]; ie = VEC[i][9];
      rx_ie = ie;
      send_frame(d, bad);
      if (!bad) exp_data = d;
      chk(rx_full == !bad, "R3/R5 rx_full", rx_full, !bad);
      chk(par_err == bad, "R5 par_err", par_err, bad);
      chk(rx_data == exp_data, "R2/R3/R5 rx_data", rx_data, exp_data);
      chk(rx_irq == (!bad && ie), "R4 rx_irq", rx_irq, !bad && ie);
      chk(err_irq == (bad && ie), "R4 err_irq", err_irq, bad && ie);
      if (bad) begin
        chk(pull_cnt == ETU, "R6 pull width", pull_cnt, ETU);
        chk(pull_mid == 1'b1, "R6 pull at 11 bits", pull_mid, 1);
      end else begin
        chk(pull_cnt == 0, "R7 no pull on good", pull_cnt, 0);
      end
      clear_flags();
      chk(rx_full == 0 && par_err == 0, "R8/R9 cleared", {rx_full, par_err}, 0);
    end

    // R8: full holds without a read, read clears it and keeps the data
    rx_ie = 1'b1;
    send_frame(8'h5A, 0);
    exp_data = 8'h5A;
    repeat (ETU) @(negedge clk);
    chk(rx_full == 1, "R8 holds without read", rx_full, 1);
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    chk(rx_full == 0 && rx_irq == 0, "R8 read clears", {rx_full, rx_irq}, 0);
    chk(rx_data == 8'h5A, "R8 data kept", rx_data, 8'h5A);

    // R10: false start shorter than half a bit
    line_tx = 1'b0;
    repeat (ETU/4) @(negedge clk);
    line_tx = 1'b1;
    repeat (2*ETU) @(negedge clk);
    chk(rx_full == 0 && par_err == 0, "R10 glitch ignored", {rx_full, par_err}, 0);
    chk(io_pull_low == 0, "R10 no pull", io_pull_low, 0);
    send_frame(8'hC3, 0);
    chk(rx_full == 1 && rx_data == 8'hC3, "R10 next frame", rx_data, 8'hC3);
    exp_data = 8'hC3;
    clear_flags();

    // R9: sticky parity error across a second bad frame
    send_frame(8'h77, 1);
    chk(par_err == 1, "R9 first error", par_err, 1);
    send_frame(8'h12, 1);
    chk(par_err == 1, "R9 second error held", par_err, 1);
    chk(rx_full == 0 && rx_data == exp_data, "R5 data kept after errors", rx_data, exp_data);
    per_clr = 1'b1; @(negedge clk); per_clr = 1'b0; @(negedge clk);
    chk(par_err == 0 && err_irq == 0, "R9 clear", {par_err, err_irq}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule